// File: doc/BRIEF.md
# UART Bit-Rate and Receive-Idle Timer

This block turns a reference clock into the two timing strobes a UART's serial shifters need. A single-cycle sample strobe marks every sample point, and a single-cycle bit strobe marks the end of each bit period. The reference clock can first be divided by eight when a mode bit asks for it. A 16-bit clock divisor then forms the sample strobe. An 8-bit per-bit divider counts sample strobes to mark each bit, so one bit lasts divisor × (bit divider + 1) prescaled clocks.

Both divisors come in as register-bus writes. The block stores a written value only when it is in range, and a running counter switches to a new value only at the end of the period it is in.

The same block also keeps a receive-idle timer. Every received byte restarts it. It counts bit periods and raises a one-cycle timeout pulse once four whole character times have passed with no new byte. The character length comes from the current frame format, and the pulse is produced only while the timeout function is enabled.

Top module: `uart_baud_gen`

## Requirements
- R1: With `prescale_i` low, `sample_tick_o` pulses once every CD clock cycles, where CD is the active clock divisor.
- R2: With `prescale_i` high, `sample_tick_o` pulses once every 8×CD clock cycles, and never in two consecutive cycles.
- R3: `bit_tick_o` pulses once every BDIV+1 sample ticks, always in a cycle where `sample_tick_o` is also high, so a bit lasts CD×(BDIV+1) prescaled cycles.
- R4: A CD write (`cd_we_i`) with `wdata_i` equal to 0 leaves `cd_o` unchanged; any other value is stored in `cd_o` on the next clock edge.
- R5: A BDIV write (`bdiv_we_i`) with `wdata_i` below 4 leaves `bdiv_o` unchanged; any other value has its low 8 bits stored in `bdiv_o` on the next clock edge.
- R6: After reset `cd_o` is 0x28B, `bdiv_o` is 0x0F and `timeout_o` is low.
- R7: A new CD takes effect only at the next sample tick: the sample period in progress when CD is written completes with the old length, and the next period uses the new one. A new BDIV takes effect at the next bit tick.
- R8: A character is 1 start bit, plus the data bits, plus 1 parity bit when parity is enabled, plus 1 stop bit (`stop2_i` low) or 2 stop bits (`stop2_i` high). `data_bits_i` = 3 selects 6 data bits, 2 selects 7, and any other code selects 8. `parity_i` = 0 (even) or 1 (odd) enables parity, and any other code disables it. `timeout_o` pulses in the cycle after the 4×(character length)-th bit tick that follows a received byte (`rx_byte_i`).
- R9: While `timeout_en_i` is low, an idle period ends without a `timeout_o` pulse.
- R10: Each `rx_byte_i` restarts the idle count from zero, and each idle period produces at most one `timeout_o` pulse, which lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | 1 | Divide the reference clock by 8 before the divisor stage |
| data_bits_i | input | 2 | Data-length code (3: 6 bits, 2: 7 bits, other: 8 bits) |
| parity_i | input | 3 | Parity code (0: even, 1: odd, other: none) |
| stop2_i | input | 1 | Two stop bits when high, one when low |
| cd_we_i | input | 1 | Write strobe for the clock divisor |
| bdiv_we_i | input | 1 | Write strobe for the per-bit divider |
| wdata_i | input | 16 | Write data for either divisor |
| rx_byte_i | input | 1 | One-cycle pulse per received byte |
| timeout_en_i | input | 1 | Timeout function enabled (timeout register nonzero) |
| sample_tick_o | output | 1 | Sample strobe |
| bit_tick_o | output | 1 | Bit-period strobe |
| timeout_o | output | 1 | Receive-idle timeout pulse |
| cd_o | output | 16 | Stored clock divisor |
| bdiv_o | output | 8 | Stored per-bit divider |

## Verification
The hardest case to reach is a divisor change that lands in the middle of a sample period, because the old length and the new one have to be told apart at the ports. The bench synchronises to a sample tick and writes a new CD one cycle later. It then measures the two following tick-to-tick gaps and expects the old length first and the new one second. The idle timer is driven with short divisors, so one bit lasts a few cycles. For each frame format the bench counts bit ticks at the ports from the byte pulse to the timeout pulse. A second byte sent in the middle of the count shows that the count restarts.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int unsigned MAX_FRAME_BITS = 12;
  localparam int unsigned FRAME_W = $clog2(MAX_FRAME_BITS + 1);

  // start + data + optional parity + stop
  function automatic logic [FRAME_W-1:0] frame_bits(input logic [1:0] dcode,
                                                    input logic [2:0] pcode,
                                                    input logic stop2);
    logic [FRAME_W-1:0] n;
    unique case (dcode)
      2'd3:    n = FRAME_W'(7);
      2'd2:    n = FRAME_W'(8);
      default: n = FRAME_W'(9);
    endcase
    if (pcode == 3'd0 || pcode == 3'd1) n = n + FRAME_W'(1);
    n = n + (stop2 ? FRAME_W'(2) : FRAME_W'(1));
    return n;
  endfunction
endpackage

// File: rtl/uart_div_regs.sv
module uart_div_regs #(
  parameter int unsigned CD_W     = 16,
  parameter int unsigned BDIV_W   = 8,
  parameter int unsigned BDIV_MIN = 4,
  parameter logic [CD_W-1:0]   CD_RST   = CD_W'(16'h028B),
  parameter logic [BDIV_W-1:0] BDIV_RST = BDIV_W'(8'h0F)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cd_we_i,
  input  logic              bdiv_we_i,
  input  logic [CD_W-1:0]   wdata_i,
  output logic [CD_W-1:0]   cd_o,
  output logic [BDIV_W-1:0] bdiv_o
);
  logic cd_ok, bdiv_ok;
  assign cd_ok   = (wdata_i != '0);
  assign bdiv_ok = (wdata_i >= CD_W'(BDIV_MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_o   <= CD_RST;
      bdiv_o <= BDIV_RST;
    end else begin
      if (cd_we_i && cd_ok)     cd_o   <= wdata_i;
      if (bdiv_we_i && bdiv_ok) bdiv_o <= wdata_i[BDIV_W-1:0];
    end
  end
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int unsigned CD_W     = 16,
  parameter int unsigned BDIV_W   = 8,
  parameter int unsigned PRESCALE = 8,
  parameter logic [CD_W-1:0]   CD_RST   = CD_W'(16'h028B),
  parameter logic [BDIV_W-1:0] BDIV_RST = BDIV_W'(8'h0F)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prescale_i,
  input  logic [CD_W-1:0]   cd_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0]  pre_cnt;
  logic              pre_tick;
  logic [CD_W-1:0]   cd_cnt, cd_act;
  logic [BDIV_W-1:0] bit_cnt, bdiv_act;

  assign pre_tick      = !prescale_i || (pre_cnt == PRE_W'(PRESCALE - 1));
  assign sample_tick_o = pre_tick && (cd_cnt == cd_act - CD_W'(1));
  assign bit_tick_o    = sample_tick_o && (bit_cnt == bdiv_act);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
    end else if (pre_cnt == PRE_W'(PRESCALE - 1)) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  // new divisor values are adopted only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_cnt   <= '0;
      cd_act   <= CD_RST;
      bit_cnt  <= '0;
      bdiv_act <= BDIV_RST;
    end else if (sample_tick_o) begin
      cd_cnt <= '0;
      cd_act <= cd_i;
      if (bit_tick_o) begin
        bit_cnt  <= '0;
        bdiv_act <= bdiv_i;
      end else begin
        bit_cnt <= bit_cnt + BDIV_W'(1);
      end
    end else if (pre_tick) begin
      cd_cnt <= cd_cnt + CD_W'(1);
    end
  end
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
  import uart_baud_pkg::*;
#(
  parameter int unsigned TO_CHARS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] data_bits_i,
  input  logic [2:0] parity_i,
  input  logic       stop2_i,
  input  logic       bit_tick_i,
  input  logic       rx_byte_i,
  input  logic       timeout_en_i,
  output logic       timeout_o
);
  localparam int unsigned TO_W = $clog2(TO_CHARS * MAX_FRAME_BITS + 1);

  logic [TO_W-1:0] idle_cnt, limit;
  logic            armed;

  assign limit = TO_W'(TO_CHARS) * TO_W'(frame_bits(data_bits_i, parity_i, stop2_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt  <= '0;
      armed     <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if (rx_byte_i) begin
        idle_cnt <= '0;
        armed    <= 1'b1;
      end else if (armed && bit_tick_i) begin
        if (idle_cnt == limit - TO_W'(1)) begin
          armed     <= 1'b0;
          timeout_o <= timeout_en_i;
        end else begin
          idle_cnt <= idle_cnt + TO_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned CD_W     = 16,
  parameter int unsigned BDIV_W   = 8,
  parameter int unsigned BDIV_MIN = 4,
  parameter int unsigned PRESCALE = 8,
  parameter int unsigned TO_CHARS = 4,
  parameter logic [CD_W-1:0]   CD_RST   = CD_W'(16'h028B),
  parameter logic [BDIV_W-1:0] BDIV_RST = BDIV_W'(8'h0F)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prescale_i,
  input  logic [1:0]        data_bits_i,
  input  logic [2:0]        parity_i,
  input  logic              stop2_i,
  input  logic              cd_we_i,
  input  logic              bdiv_we_i,
  input  logic [CD_W-1:0]   wdata_i,
  input  logic              rx_byte_i,
  input  logic              timeout_en_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o,
  output logic              timeout_o,
  output logic [CD_W-1:0]   cd_o,
  output logic [BDIV_W-1:0] bdiv_o
);
  uart_div_regs #(
    .CD_W(CD_W), .BDIV_W(BDIV_W), .BDIV_MIN(BDIV_MIN),
    .CD_RST(CD_RST), .BDIV_RST(BDIV_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cd_we_i(cd_we_i), .bdiv_we_i(bdiv_we_i), .wdata_i(wdata_i),
    .cd_o(cd_o), .bdiv_o(bdiv_o)
  );

  uart_tick_gen #(
    .CD_W(CD_W), .BDIV_W(BDIV_W), .PRESCALE(PRESCALE),
    .CD_RST(CD_RST), .BDIV_RST(BDIV_RST)
  ) u_ticks (
    .clk_i(clk_i), .rst_ni(rst_ni), .prescale_i(prescale_i),
    .cd_i(cd_o), .bdiv_i(bdiv_o),
    .sample_tick_o(sample_tick_o), .bit_tick_o(bit_tick_o)
  );

  uart_rx_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .data_bits_i(data_bits_i), .parity_i(parity_i), .stop2_i(stop2_i),
    .bit_tick_i(bit_tick_o), .rx_byte_i(rx_byte_i),
    .timeout_en_i(timeout_en_i), .timeout_o(timeout_o)
  );
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
  parameter int unsigned CD_W   = 16,
  parameter int unsigned BDIV_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prescale_i,
  input logic              cd_we_i,
  input logic              bdiv_we_i,
  input logic [CD_W-1:0]   wdata_i,
  input logic              timeout_en_i,
  input logic              sample_tick_o,
  input logic              bit_tick_o,
  input logic              timeout_o,
  input logic [CD_W-1:0]   cd_o,
  input logic [BDIV_W-1:0] bdiv_o
);
  assert_prescale_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_o && prescale_i |=> !prescale_i || !sample_tick_o);

  assert_bit_on_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);

  assert_cd_zero_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_we_i && (wdata_i == '0) |=> $stable(cd_o));

  assert_cd_stored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_we_i && (wdata_i != '0) |=> cd_o == $past(wdata_i));

  assert_bdiv_small_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bdiv_we_i && (wdata_i < CD_W'(4)) |=> $stable(bdiv_o));

  assert_timeout_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(timeout_en_i && bit_tick_o));

  assert_timeout_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.CD_W(CD_W), .BDIV_W(BDIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prescale_i(prescale_i),
  .cd_we_i(cd_we_i), .bdiv_we_i(bdiv_we_i), .wdata_i(wdata_i),
  .timeout_en_i(timeout_en_i), .sample_tick_o(sample_tick_o),
  .bit_tick_o(bit_tick_o), .timeout_o(timeout_o),
  .cd_o(cd_o), .bdiv_o(bdiv_o)
);

// File: tb/uart_baud_gen_tb.sv
`timescale 1ns/1ps
module uart_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prescale = 1'b0;
  logic [1:0]  dbits = 2'd0;
  logic [2:0]  par = 3'd4;
  logic        stop2 = 1'b0;
  logic        cd_we = 1'b0, bdiv_we = 1'b0;
  logic [15:0] wdata = '0;
  logic        rx_byte = 1'b0;
  logic        to_en = 1'b0;
  logic        sample_tick, bit_tick, timeout;
  logic [15:0] cd;
  logic [7:0]  bdiv;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_baud_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prescale_i(prescale),
    .data_bits_i(dbits), .parity_i(par), .stop2_i(stop2),
    .cd_we_i(cd_we), .bdiv_we_i(bdiv_we), .wdata_i(wdata),
    .rx_byte_i(rx_byte), .timeout_en_i(to_en),
    .sample_tick_o(sample_tick), .bit_tick_o(bit_tick), .timeout_o(timeout),
    .cd_o(cd), .bdiv_o(bdiv)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cd(logic [15:0] v);
    @(negedge clk); cd_we = 1'b1; wdata = v;
    @(negedge clk); cd_we = 1'b0;
  endtask

  task automatic wr_bdiv(logic [15:0] v);
    @(negedge clk); bdiv_we = 1'b1; wdata = v;
    @(negedge clk); bdiv_we = 1'b0;
  endtask

  task automatic sync_sample();
    do @(negedge clk); while (!sample_tick);
  endtask

  task automatic sample_gap(output int p);
    p = 0;
    do begin @(negedge clk); p++; end while (!sample_tick);
  endtask

  task automatic sync_bit();
    do @(negedge clk); while (!bit_tick);
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_byte = 1'b1;
    @(negedge clk); rx_byte = 1'b0;
  endtask

  task automatic test_reset();
    check_eq("R6", "cd reset", int'(cd), 'h28B);
    check_eq("R6", "bdiv reset", int'(bdiv), 'h0F);
    check_eq("R6", "timeout reset", int'(timeout), 0);
  endtask

  task automatic test_cd_write();
    wr_cd(16'h0000);
    check_eq("R4", "cd after zero write", int'(cd), 'h28B);
    wr_cd(16'h0005);
    check_eq("R4", "cd after write 5", int'(cd), 5);
  endtask

  task automatic test_period_plain();
    int p;
    sync_sample(); sync_sample();
    sample_gap(p);
    check_eq("R1", "sample period cd=5", p, 5);
  endtask

  task automatic test_midperiod_update();
    int p;
    sync_sample();
    @(negedge clk); cd_we = 1'b1; wdata = 16'd9;
    @(negedge clk); cd_we = 1'b0;
    p = 2;
    while (!sample_tick) begin @(negedge clk); p++; end
    check_eq("R7", "period in flight keeps old cd", p, 5);
    sample_gap(p);
    check_eq("R7", "next period uses new cd", p, 9);
  endtask

  task automatic test_prescale();
    int p;
    wr_cd(16'd3);
    prescale = 1'b1;
    sync_sample(); sync_sample(); sync_sample();
    sample_gap(p);
    check_eq("R2", "prescaled period cd=3", p, 24);
    prescale = 1'b0;
    sync_sample(); sync_sample();
    sample_gap(p);
    check_eq("R1", "sample period cd=3", p, 3);
  endtask

  task automatic test_bdiv_write();
    wr_bdiv(16'd2);
    check_eq("R5", "bdiv after write 2", int'(bdiv), 'h0F);
    wr_bdiv(16'd3);
    check_eq("R5", "bdiv after write 3", int'(bdiv), 'h0F);
    wr_bdiv(16'h0107);
    check_eq("R5", "bdiv low byte stored", int'(bdiv), 7);
    wr_bdiv(16'd4);
    check_eq("R5", "bdiv after write 4", int'(bdiv), 4);
  endtask

  task automatic test_bit_period();
    int p, s;
    sync_bit(); sync_bit();
    p = 0; s = 0;
    do begin
      @(negedge clk); p++;
      if (sample_tick) s++;
    end while (!bit_tick);
    check_eq("R3", "bit period cycles cd=3 bdiv=4", p, 15);
    check_eq("R3", "sample ticks per bit", s, 5);
  endtask

  task automatic run_timeout(string req, logic [1:0] dc, logic [2:0] pc,
                             logic s2, logic en, int exp_bits);
    int nbits, seen_at, hits;
    dbits = dc; par = pc; stop2 = s2; to_en = en;
    pulse_rx();
    nbits = 0; seen_at = -1; hits = 0;
    while (nbits < exp_bits + 30) begin
      if (timeout) begin
        hits++;
        if (seen_at < 0) seen_at = nbits;
      end
      if (bit_tick) nbits++;
      @(negedge clk);
    end
    if (en) begin
      check_eq(req, "bit ticks to timeout", seen_at, exp_bits);
      check_eq("R10", "timeout pulses per idle", hits, 1);
    end else begin
      check_eq(req, "timeout pulses when disabled", hits, 0);
    end
  endtask

  task automatic test_restart();
    int nbits, seen_at, hits;
    dbits = 2'd3; par = 3'd0; stop2 = 1'b0; to_en = 1'b1;
    pulse_rx();
    nbits = 0; hits = 0;
    while (nbits < 20) begin
      if (timeout) hits++;
      if (bit_tick) nbits++;
      @(negedge clk);
    end
    pulse_rx();
    nbits = 0; seen_at = -1;
    while (nbits < 60) begin
      if (timeout) begin
        hits++;
        if (seen_at < 0) seen_at = nbits;
      end
      if (bit_tick) nbits++;
      @(negedge clk);
    end
    check_eq("R10", "restarted idle count", seen_at, 36);
    check_eq("R10", "single pulse after restart", hits, 1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_cd_write();
    test_period_plain();
    test_midperiod_update();
    test_prescale();
    test_bdiv_write();
    test_bit_period();
    wr_cd(16'd1);
    sync_bit(); sync_bit();
    // 6 data, even parity, 1 stop: 9 bits
    run_timeout("R8", 2'd3, 3'd0, 1'b0, 1'b1, 36);
    // 8 data, odd parity, 2 stop: 12 bits
    run_timeout("R8", 2'd0, 3'd1, 1'b1, 1'b1, 48);
    // 7 data, no parity, 2 stop: 10 bits
    run_timeout("R8", 2'd2, 3'd4, 1'b1, 1'b1, 40);
    run_timeout("R9", 2'd3, 3'd0, 1'b0, 1'b0, 36);
    test_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule